// File: doc/BRIEF.md
# UART Line Status and Break Tracker

This block works next to a UART receiver and transmitter and maintains the 8-bit line status word that a host reads. It watches the oversampled serial input for a break. When it sees one, it writes a single all-zero character carrying a break tag into its receive queue. Characters delivered by the receiver enter the same queue together with their parity and framing results. Those tags reach the status word only while their character is at the queue head. From the transmitter side the block keeps a count of characters waiting to be sent. It combines that count with the shift-register state to produce the transmit-ready and transmitter-empty bits. It also raises a line-status interrupt.

In queued mode the receive store holds sixteen entries and the transmit count holds up to sixteen. In single-character mode both are limited to one entry, and bit 7 of the status word reads zero. The mode input is expected to stay constant while either side holds data.

Top module: `uart_line_status`

## Requirements
- R1: With 16 sample ticks per bit and a frame of start + 8 data + 1 parity + 1 stop bits (176 ticks), a break is recognised on the 177th consecutive low-sampled tick and not earlier.
- R2: A break loads exactly one entry with zero data and the break tag, however long the line then stays low. While the block waits to re-arm (`rx_armed` = 0), `rx_valid` characters are dropped. A break detected in the same cycle as `rx_valid` wins.
- R3: After a break, `rx_armed` returns to 1 on the 8th consecutive high-sampled tick. A low tick restarts that count.
- R4: Each entry stores its parity, framing and break tags. Status bit 2 (parity), bit 3 (framing) and bit 4 (break) show only the head entry's tags, and read 0 when the queue is empty.
- R5: A status read (`lsr_rd`) clears bit 1 (overrun). It also hides the current head's tags in bits 2-4 until the head changes.
- R6: Bit 5 (transmit ready) is 1 when no character is waiting. A host write (`thr_wr`) clears it. `tx_load` removes one waiting character. Up to 16 may wait in queued mode and 1 in single-character mode, and extra writes are ignored.
- R7: Bit 6 (transmitter empty) is 1 only when no character is waiting and `tsr_busy` is 0.
- R8: Bit 7 is always 0 in single-character mode. In queued mode it sets when a tagged entry is written and stays set. A status read clears it only if no tagged entry remains in the queue at that read.
- R9: `rls_irq` is 1 when `rls_ie` is 1 and any of status bits 1-4 is 1, and is 0 otherwise.
- R10: Entries leave in arrival order on `rx_pop`, and `rx_head` shows the head data. Bit 0 (data ready) is 1 whenever the queue is non-empty. Capacity is 16 in queued mode and 1 in single-character mode.
- R11: A character (or break) arriving while the queue is full sets bit 1 and is discarded, and the stored entries are unchanged.
- R12: After reset the status word is 0x60, `rls_irq` is 0 and `rx_armed` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = queued mode, 0 = single-character mode |
| rls_ie | input | 1 | Line-status interrupt enable |
| sample_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_line | input | 1 | Serial input level |
| rx_valid | input | 1 | Receiver delivers a character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error for this character |
| rx_ferr | input | 1 | Framing error for this character |
| rx_pop | input | 1 | Host takes the head character |
| lsr_rd | input | 1 | Host reads the status word |
| thr_wr | input | 1 | Host writes a transmit character |
| tx_load | input | 1 | Transmitter takes a waiting character into its shift register |
| tsr_busy | input | 1 | Shift register holds a character |
| lsr | output | 8 | Line status word |
| rx_head | output | 8 | Data of the head entry (0 when empty) |
| rls_irq | output | 1 | Receiver line-status interrupt |
| rx_armed | output | 1 | Receiver may search for a start bit |

## Verification
The hardest state to reach from the ports is a break that has been loaded but not yet released. In that state the line is still low, a second break threshold has already passed, and the receiver may present characters that must be dropped. The bench holds the sample tick high every cycle and keeps the line low for exactly 176 ticks, then for one more tick, then for several hundred more. During that long low stretch it injects a valid character. It then proves that only one entry arrived by popping and watching data-ready fall. The re-arm count is tested by inserting a single low tick partway through the high run.

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int PARITY_BITS = 1,
  parameter int STOP_BITS   = 1,
  parameter int RX_DEPTH    = 16,
  parameter int TX_DEPTH    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fifo_mode,
  input  logic                 rls_ie,
  input  logic                 sample_tick,
  input  logic                 rx_line,
  input  logic                 rx_valid,
  input  logic [DATA_BITS-1:0] rx_data,
  input  logic                 rx_perr,
  input  logic                 rx_ferr,
  input  logic                 rx_pop,
  input  logic                 lsr_rd,
  input  logic                 thr_wr,
  input  logic                 tx_load,
  input  logic                 tsr_busy,
  output logic [7:0]           lsr,
  output logic [DATA_BITS-1:0] rx_head,
  output logic                 rls_irq,
  output logic                 rx_armed
);

  localparam int FRAME_BITS = 1 + DATA_BITS + PARITY_BITS + STOP_BITS;
  localparam int BRK_TICKS  = FRAME_BITS * OSR;
  localparam int HALF_TICKS = OSR / 2;
  localparam int LW = $clog2(BRK_TICKS + 1);
  localparam int HW = $clog2(HALF_TICKS + 1);
  localparam int AW = $clog2(RX_DEPTH);
  localparam int CW = $clog2(RX_DEPTH + 1);
  localparam int TW = $clog2(TX_DEPTH + 1);
  localparam int EW = DATA_BITS + 3;

  logic [EW-1:0] mem [RX_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, tag_cnt;
  logic [LW-1:0] low_cnt;
  logic [HW-1:0] hi_cnt;
  logic [TW-1:0] tx_cnt;
  logic          brk_hold, head_seen, ovr, err_sum;

  wire low_tick = sample_tick && !rx_line;
  wire hi_tick  = sample_tick && rx_line;
  wire brk_fire = low_tick && !brk_hold && (low_cnt == LW'(BRK_TICKS));
  wire rearm    = hi_tick && brk_hold && (hi_cnt == HW'(HALF_TICKS - 1));

  wire [CW-1:0] rx_cap   = fifo_mode ? CW'(RX_DEPTH) : CW'(1);
  wire          push_req = brk_fire || (rx_valid && !brk_hold);
  wire [EW-1:0] push_ent = brk_fire ? {1'b1, 2'b00, {DATA_BITS{1'b0}}}
                                    : {1'b0, rx_ferr, rx_perr, rx_data};
  wire          full     = cnt >= rx_cap;
  wire          push     = push_req && !full;
  wire          pop      = rx_pop && (cnt != '0);
  wire [EW-1:0] head     = mem[rp];
  wire          push_tag = |push_ent[EW-1:DATA_BITS];
  wire          pop_tag  = |head[EW-1:DATA_BITS];
  wire [2:0]    head_tags = ((cnt != '0) && !head_seen) ? head[EW-1:DATA_BITS] : 3'b000;

  wire [TW-1:0] tx_cap = fifo_mode ? TW'(TX_DEPTH) : TW'(1);
  wire          tx_inc = thr_wr && (tx_cnt < tx_cap);
  wire          tx_dec = tx_load && (tx_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      hi_cnt   <= '0;
      brk_hold <= 1'b0;
    end else begin
      if (low_tick)
        low_cnt <= (low_cnt == LW'(BRK_TICKS)) ? low_cnt : low_cnt + LW'(1);
      else if (hi_tick)
        low_cnt <= '0;

      if (brk_fire)   brk_hold <= 1'b1;
      else if (rearm) brk_hold <= 1'b0;

      if (!brk_hold || low_tick) hi_cnt <= '0;
      else if (hi_tick)          hi_cnt <= hi_cnt + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      tag_cnt   <= '0;
      head_seen <= 1'b0;
      ovr       <= 1'b0;
      err_sum   <= 1'b0;
      tx_cnt    <= '0;
    end else begin
      if (push) wp <= (wp == AW'(RX_DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(RX_DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt     <= cnt + CW'(push) - CW'(pop);
      tag_cnt <= tag_cnt + CW'(push && push_tag) - CW'(pop && pop_tag);

      if (pop || cnt == '0) head_seen <= 1'b0;
      else if (lsr_rd)      head_seen <= 1'b1;

      if (push_req && full) ovr <= 1'b1;
      else if (lsr_rd)      ovr <= 1'b0;

      if (push && push_tag)               err_sum <= 1'b1;
      else if (lsr_rd && tag_cnt == '0)   err_sum <= 1'b0;

      tx_cnt <= tx_cnt + TW'(tx_inc) - TW'(tx_dec);
    end
  end

  assign lsr = {fifo_mode && err_sum,
                (tx_cnt == '0) && !tsr_busy,
                tx_cnt == '0,
                head_tags,
                ovr,
                cnt != '0};
  assign rx_head  = (cnt != '0) ? head[DATA_BITS-1:0] : '0;
  assign rls_irq  = rls_ie && (ovr || (|head_tags));
  assign rx_armed = !brk_hold;

endmodule

module uart_line_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_mode,
  input logic       rls_ie,
  input logic       rx_line,
  input logic       rx_valid,
  input logic       rx_pop,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic       tx_load,
  input logic       tsr_busy,
  input logic [7:0] lsr,
  input logic       rls_irq,
  input logic       rx_armed
);

  AST_BRK_LOADS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_armed) |-> lsr[0]); // R2

  AST_REARM_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_armed) |-> (rx_line && $past(rx_line))); // R3

  AST_EMPTY_NO_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> (lsr[4:2] == 3'b000)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && rx_line && !rx_pop) |=> (lsr[4:1] == 4'b0000)); // R5

  AST_WRITE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_load) |=> !lsr[5]); // R6

  AST_TEMT_BOTH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> (lsr[5] && !tsr_busy)); // R7

  AST_SUMMARY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !lsr[7]); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rls_irq |-> (rls_ie && (lsr[4:1] != 4'b0000))); // R9

endmodule

bind uart_line_status uart_line_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rls_ie(rls_ie),
  .rx_line(rx_line), .rx_valid(rx_valid), .rx_pop(rx_pop), .lsr_rd(lsr_rd),
  .thr_wr(thr_wr), .tx_load(tx_load), .tsr_busy(tsr_busy), .lsr(lsr),
  .rls_irq(rls_irq), .rx_armed(rx_armed)
);

// File: tb/uart_line_status_tb.sv
module uart_line_status_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode = 1'b1, rls_ie = 1'b0, sample_tick = 1'b1, rx_line = 1'b1;
  logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_pop = 1'b0, lsr_rd = 1'b0, thr_wr = 1'b0, tx_load = 1'b0, tsr_busy = 1'b0;
  logic [7:0] lsr, rx_head;
  logic       rls_irq, rx_armed;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  uart_line_status dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rls_ie(rls_ie),
    .sample_tick(sample_tick), .rx_line(rx_line), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_pop(rx_pop),
    .lsr_rd(lsr_rd), .thr_wr(thr_wr), .tx_load(tx_load), .tsr_busy(tsr_busy),
    .lsr(lsr), .rx_head(rx_head), .rls_irq(rls_irq), .rx_armed(rx_armed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d, input logic pe, input logic fe);
    rx_valid = 1'b1; rx_data = d; rx_perr = pe; rx_ferr = fe;
    step();
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic pop();     rx_pop = 1'b1;  step(); rx_pop = 1'b0;  endtask
  task automatic rd();      lsr_rd = 1'b1;  step(); lsr_rd = 1'b0;  endtask
  task automatic wr();      thr_wr = 1'b1;  step(); thr_wr = 1'b0;  endtask
  task automatic load();    tx_load = 1'b1; step(); tx_load = 1'b0; endtask

  task automatic t_reset();
    chk("R12 status after reset", lsr, 8'h60);
    chk("R12 irq after reset", rls_irq, 0);
    chk("R12 armed after reset", rx_armed, 1);
  endtask

  task automatic t_order();
    fifo_mode = 1'b1;
    push(8'hA5, 0, 0);
    push(8'h3C, 0, 0);
    chk("R10 data ready", lsr[0], 1);
    chk("R10 first head", rx_head, 8'hA5);
    pop();
    chk("R10 second head", rx_head, 8'h3C);
    pop();
    chk("R10 drained status", lsr, 8'h60);
  endtask

  task automatic t_tags();
    rls_ie = 1'b1;
    push(8'h11, 0, 0);
    push(8'h22, 1, 0);
    push(8'h33, 0, 1);
    chk("R4 clean head hides tags", lsr[4:2], 0);
    chk("R8 summary set", lsr[7], 1);
    chk("R9 no irq on clean head", rls_irq, 0);
    pop();
    chk("R4 parity at head", lsr[4:1], 4'b0010);
    chk("R9 irq raised", rls_irq, 1);
    rd();
    chk("R5 read hides head tags", lsr[4:1], 0);
    chk("R9 irq drops after read", rls_irq, 0);
    chk("R8 summary held, tagged remain", lsr[7], 1);
    pop();
    chk("R4 framing at head", lsr[4:1], 4'b0100);
    rd();
    chk("R8 summary held, head still tagged", lsr[7], 1);
    pop();
    chk("R8 summary held after drain", lsr[7], 1);
    rd();
    chk("R8 summary cleared", lsr[7], 0);
    rls_ie = 1'b0;
    push(8'h44, 1, 0);
    chk("R9 flag without enable", lsr[2], 1);
    chk("R9 irq masked", rls_irq, 0);
    pop();
    rd();
  endtask

  task automatic t_break();
    rx_line = 1'b0;
    repeat (176) step();
    chk("R1 no break at frame time", lsr[0], 0);
    step();
    chk("R1 break loaded", lsr[0], 1);
    chk("R2 break tag", lsr[4], 1);
    chk("R2 zero char", rx_head, 0);
    chk("R3 disarmed", rx_armed, 0);
    repeat (400) step();
    push(8'h55, 0, 0);
    chk("R2 held head", rx_head, 0);
    pop();
    chk("R2 single entry", lsr[0], 0);
    rx_line = 1'b1;
    repeat (5) step();
    rx_line = 1'b0;
    step();
    rx_line = 1'b1;
    repeat (7) step();
    chk("R3 still waiting", rx_armed, 0);
    step();
    chk("R3 re-armed", rx_armed, 1);
    push(8'h55, 0, 0);
    chk("R2 accepts after re-arm", rx_head, 8'h55);
    pop();
    rd();
    chk("R8 summary cleared after break", lsr[7], 0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 1), 0, 0);
    chk("R11 no overrun at full", lsr[1], 0);
    push(8'hEE, 0, 0);
    chk("R11 overrun set", lsr[1], 1);
    chk("R11 head unchanged", rx_head, 8'h01);
    rd();
    chk("R5 overrun cleared", lsr[1], 0);
    for (int i = 0; i < 16; i++) begin
      chk("R11 contents kept", rx_head, 8'(i * 7 + 1));
      pop();
    end
    chk("R11 empty after drain", lsr[0], 0);
  endtask

  task automatic t_single();
    fifo_mode = 1'b0;
    push(8'h44, 1, 0);
    chk("R8 bit7 zero in single mode", lsr[7], 0);
    chk("R4 parity shown", lsr[2], 1);
    push(8'h45, 0, 0);
    chk("R10 capacity one -> overrun", lsr[1], 1);
    chk("R11 kept first", rx_head, 8'h44);
    pop();
    rd();
    wr();
    wr();
    chk("R6 not ready after write", lsr[5], 0);
    load();
    chk("R6 single holds one", lsr[5], 1);
    fifo_mode = 1'b1;
  endtask

  task automatic t_tx();
    wr();
    chk("R6 write clears ready", lsr[5], 0);
    chk("R7 not empty", lsr[6], 0);
    wr();
    load();
    chk("R6 one still waiting", lsr[5], 0);
    tsr_busy = 1'b1;
    load();
    chk("R6 ready after last load", lsr[5], 1);
    chk("R7 shift busy", lsr[6], 0);
    tsr_busy = 1'b0;
    step();
    chk("R7 all empty", lsr[6], 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_order();
    t_tags();
    t_break();
    t_overrun();
    t_single();
    t_tx();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule